// File: doc/BRIEF.md
# Boot EEPROM Load Sequencer

This block decides when a device fetches its configuration from an external serial EEPROM and then follows that fetch to its end. A fetch can be triggered in two ways. The first is the active-low read-enable pin, which counts only when the bus-master strap is set. The second is a control-register command, which works whatever the strap says. The block issues a one-cycle start request to a separate EEPROM read engine. It then waits for that engine's done or error response, and a local timeout covers the case where neither arrives.

A fetch runs only once. After a good completion the block ignores every trigger until software re-arms it. A disable bit can hold off a fetch, but only while the block is armed and idle. A small register file holds the control bits, a sticky completion flag, a sticky error flag and a fixed device-identification field. A self-clearing soft-reset command returns the shared registers to their defaults.

Top module: `boot_load_seq`

## Requirements
- R1: In the armed state, with `strap_master` high and `rd_en_n` low at a rising edge, `load_start` is high for the cycle after that edge and `load_busy` goes high at the same edge. The pin is level-sensitive.
- R2: In the armed state, a write to the control register (address 0x02) with bit 0 (load-now) set starts a load at that edge, for either value of `strap_master`. Load-now always reads back as 0.
- R3: A one-cycle `eng_done` while busy ends the load. It sets the completion flag, which is bit 0 of the status register (address 0x03), and that flag stays set.
- R4: After a completed load, neither load-now nor a low `rd_en_n` starts another load. `load_start` and `load_busy` stay low and the status register stays at 0x01.
- R5: Control bit 1 (re-arm) keeps its written value and is not self-clearing. While it is 1, no load starts and the status flags read 0. Once it is cleared, a `rd_en_n` that is still low starts a load at the next edge.
- R6: Control bit 2 (disable) stops any load from starting while the block is armed. Setting it during a load changes nothing, and that load still completes.
- R7: A single control write that sets both disable and load-now starts no load.
- R8: Control bit 7 (soft reset) clears the control and status registers and returns the block to the armed state. The bit reads back as 0.
- R9: Register 0x01 is read-only and reads {REV[2:0], 5'h10}, which is 0x30 for the default REV of 1.
- R10: An `eng_err`, or a load that stays busy for TIMEOUT_CYC cycles, returns the block to the armed state and sets status bit 1 (error). Status bit 2 mirrors `load_busy`.
- R11: After reset, `load_start` and `load_busy` are low and the control and status registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_master | input | 1 | Bus-master strap; enables the read-enable pin trigger |
| rd_en_n | input | 1 | Active-low read-enable pin, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr, one cycle late |
| load_start | output | 1 | One-cycle start request to the read engine |
| load_busy | output | 1 | A load is in progress |
| eng_done | input | 1 | Read engine finished successfully |
| eng_err | input | 1 | Read engine failed |

## Verification
The assertions assume the following about the inputs. `rd_en_n` and `strap_master` are already synchronous to `clk`. `eng_done` and `eng_err` are single-cycle pulses that arrive only while a load is busy. Register writes are single-cycle strobes. The bench drives every input at the falling edge from tasks, pulses the engine responses only after it has seen `load_busy` high, and releases `rd_en_n` before each soft reset so that no unintended load starts. The timeout check is bounded by a counter in the checker, not by a delay in the property.

// File: rtl/boot_load_pkg.sv
package boot_load_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DONE  = 2'd2
  } bl_state_t;

  localparam logic [7:0] ADDR_ID     = 8'h01;
  localparam logic [7:0] ADDR_CTRL   = 8'h02;
  localparam logic [7:0] ADDR_STATUS = 8'h03;

  localparam int BIT_NOW   = 0;
  localparam int BIT_REARM = 1;
  localparam int BIT_DIS   = 2;
  localparam int BIT_SOFT  = 7;

  localparam int BIT_ST_DONE = 0;
  localparam int BIT_ST_ERR  = 1;
  localparam int BIT_ST_BUSY = 2;

  localparam logic [4:0] DEV_ID = 5'h10;
endpackage

// File: rtl/boot_csr.sv
module boot_csr
  import boot_load_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 8,
  parameter logic [2:0]  REV    = 3'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              set_done,
  input  logic              set_err,
  output logic [DATA_W-1:0] rdata,
  output logic              rearm_q,
  output logic              dis_q,
  output logic              done_q,
  output logic              dis_eff,
  output logic              load_now_wr,
  output logic              soft_rst
);
  logic ctrl_wr;
  logic err_q;
  logic [DATA_W-1:0] rd_mux;

  assign ctrl_wr     = wr && (addr == ADDR_W'(ADDR_CTRL));
  assign soft_rst    = ctrl_wr && wdata[BIT_SOFT];
  assign load_now_wr = ctrl_wr && wdata[BIT_NOW] && !soft_rst;
  assign dis_eff     = dis_q || (ctrl_wr && wdata[BIT_DIS]);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      rearm_q <= 1'b0;
      dis_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        rearm_q <= wdata[BIT_REARM];
        dis_q   <= wdata[BIT_DIS];
      end
      if (rearm_q) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (set_done) done_q <= 1'b1;
        if (set_err)  err_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADDR_ID)) begin
      rd_mux[4:0] = DEV_ID;
      rd_mux[7:5] = REV;
    end else if (addr == ADDR_W'(ADDR_CTRL)) begin
      rd_mux[BIT_REARM] = rearm_q;
      rd_mux[BIT_DIS]   = dis_q;
    end else if (addr == ADDR_W'(ADDR_STATUS)) begin
      rd_mux[BIT_ST_DONE] = done_q;
      rd_mux[BIT_ST_ERR]  = err_q;
      rd_mux[BIT_ST_BUSY] = busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int TIMEOUT_CYC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import boot_load_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      strap_master,
  input  logic      rd_en_n,
  input  logic      load_now_wr,
  input  logic      dis_eff,
  input  logic      rearm,
  input  logic      soft_rst,
  input  logic      eng_done,
  input  logic      eng_err,
  input  logic      expired,
  output bl_state_t st,
  output logic      load_start,
  output logic      set_done,
  output logic      set_err
);
  bl_state_t nxt;
  logic      go;

  always_comb begin
    nxt      = st;
    go       = 1'b0;
    set_done = 1'b0;
    set_err  = 1'b0;
    if (soft_rst || rearm) begin
      nxt = ST_ARMED;
    end else begin
      case (st)
        ST_ARMED: begin
          if (!dis_eff && (load_now_wr || (strap_master && !rd_en_n))) begin
            nxt = ST_BUSY;
            go  = 1'b1;
          end
        end
        ST_BUSY: begin
          if (eng_err || expired) begin
            nxt     = ST_ARMED;
            set_err = 1'b1;
          end else if (eng_done) begin
            nxt      = ST_DONE;
            set_done = 1'b1;
          end
        end
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_ARMED;
      load_start <= 1'b0;
    end else begin
      st         <= nxt;
      load_start <= go;
    end
  end
endmodule

// File: rtl/boot_load_seq.sv
module boot_load_seq
  import boot_load_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 8,
  parameter logic [2:0] REV         = 3'd1,
  parameter int         TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_master,
  input  logic              rd_en_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              load_start,
  output logic              load_busy,
  input  logic              eng_done,
  input  logic              eng_err
);
  bl_state_t st;
  logic rearm_q, dis_q, done_q, dis_eff, load_now_wr, soft_rst;
  logic set_done, set_err, expired;

  assign load_busy = (st == ST_BUSY);

  boot_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REV(REV)) u_csr (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(load_busy), .set_done(set_done), .set_err(set_err),
    .rdata(reg_rdata), .rearm_q(rearm_q), .dis_q(dis_q), .done_q(done_q),
    .dis_eff(dis_eff), .load_now_wr(load_now_wr), .soft_rst(soft_rst)
  );

  boot_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run(load_busy), .expired(expired)
  );

  boot_fsm u_fsm (
    .clk(clk), .rst(rst), .strap_master(strap_master), .rd_en_n(rd_en_n),
    .load_now_wr(load_now_wr), .dis_eff(dis_eff), .rearm(rearm_q),
    .soft_rst(soft_rst), .eng_done(eng_done), .eng_err(eng_err),
    .expired(expired), .st(st), .load_start(load_start),
    .set_done(set_done), .set_err(set_err)
  );
endmodule

// File: rtl/boot_load_seq_chk.sv
module boot_load_seq_chk
  import boot_load_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256
) (
  input logic      clk,
  input logic      rst,
  input logic      load_start,
  input logic      load_busy,
  input bl_state_t st,
  input logic      rearm_q,
  input logic      dis_q,
  input logic      done_q,
  input logic      soft_rst
);
  localparam int RUN_W = $clog2(TIMEOUT_CYC + 2);
  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !load_busy) busy_run <= '0;
    else if (busy_run != RUN_W'(TIMEOUT_CYC + 1)) busy_run <= busy_run + 1'b1;
  end

  a_r1_busy_rises_with_start: assert property (@(posedge clk) disable iff (rst)
    $rose(load_busy) |-> load_start);
  a_r2_start_single_cycle: assert property (@(posedge clk) disable iff (rst)
    load_start |=> !load_start);
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_q && !rearm_q && !soft_rst) |=> done_q);
  a_r4_no_restart_after_done: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE && !rearm_q && !soft_rst) |=> !load_start);
  a_r6_disable_blocks: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARMED && dis_q) |=> !load_busy);
  a_r8_soft_clears: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!rearm_q && !dis_q && !done_q && !load_busy));
  a_r10_timeout_bound: assert property (@(posedge clk) disable iff (rst)
    busy_run <= RUN_W'(TIMEOUT_CYC));
endmodule

bind boot_load_seq boot_load_seq_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst(rst), .load_start(load_start), .load_busy(load_busy),
  .st(st), .rearm_q(rearm_q), .dis_q(dis_q), .done_q(done_q),
  .soft_rst(soft_rst)
);

// File: tb/tb_boot_load_seq.sv
`timescale 1ns/1ps
module tb_boot_load_seq;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_master = 1'b0;
  logic rd_en_n = 1'b1;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic load_start, load_busy;
  logic eng_done = 1'b0;
  logic eng_err = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  boot_load_seq #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .strap_master(strap_master), .rd_en_n(rd_en_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .load_start(load_start), .load_busy(load_busy),
    .eng_done(eng_done), .eng_err(eng_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk); eng_err = 1'b1;
    @(negedge clk); eng_err = 1'b0;
  endtask

  task automatic soft_reset();
    rd_en_n = 1'b1;
    wr(8'h02, 8'h80);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 load_start", load_start, 0);
    chk("R11 load_busy", load_busy, 0);
    rd(8'h02, v); chk("R11 ctrl", v, 8'h00);
    rd(8'h03, v); chk("R11 status", v, 8'h00);
  endtask

  task automatic t_id();
    logic [7:0] v;
    rd(8'h01, v); chk("R9 id", v, 8'h30);
  endtask

  task automatic t_immediate_and_done();
    logic [7:0] v;
    strap_master = 1'b0;
    wr(8'h02, 8'h01);
    chk("R2 start", load_start, 1);
    chk("R2 busy", load_busy, 1);
    @(negedge clk);
    chk("R2 start one cycle", load_start, 0);
    rd(8'h03, v); chk("R10 status busy bit", v, 8'h04);
    rd(8'h02, v); chk("R2 load-now reads 0", v, 8'h00);
    pulse_done();
    chk("R3 busy cleared", load_busy, 0);
    rd(8'h03, v); chk("R3 done flag", v, 8'h01);
    wr(8'h02, 8'h01);
    chk("R4 no start on load-now", load_start, 0);
    strap_master = 1'b1; rd_en_n = 1'b0;
    idle(3);
    chk("R4 no busy on pin", load_busy, 0);
    rd(8'h03, v); chk("R4 status kept", v, 8'h01);
  endtask

  task automatic t_rearm();
    logic [7:0] v;
    wr(8'h02, 8'h02);
    idle(2);
    chk("R5 no start while rearm", load_busy, 0);
    rd(8'h02, v); chk("R5 rearm sticks", v, 8'h02);
    rd(8'h03, v); chk("R5 flags cleared", v, 8'h00);
    wr(8'h02, 8'h00);
    chk("R5 not yet", load_start, 0);
    @(negedge clk);
    chk("R5 level restart", load_start, 1);
    pulse_done();
    rd(8'h03, v); chk("R5 second done", v, 8'h01);
  endtask

  task automatic t_soft_and_pin();
    logic [7:0] v;
    wr(8'h02, 8'h06);
    soft_reset();
    chk("R8 busy", load_busy, 0);
    rd(8'h02, v); chk("R8 ctrl default", v, 8'h00);
    rd(8'h03, v); chk("R8 status default", v, 8'h00);
    @(negedge clk); rd_en_n = 1'b0;
    @(negedge clk);
    chk("R1 pin start", load_start, 1);
    chk("R1 busy", load_busy, 1);
    pulse_done();
    soft_reset();
  endtask

  task automatic t_disable();
    logic [7:0] v;
    strap_master = 1'b1;
    wr(8'h02, 8'h04);
    rd_en_n = 1'b0;
    idle(3);
    chk("R6 pin blocked", load_busy, 0);
    wr(8'h02, 8'h05);
    chk("R6 load-now blocked", load_start, 0);
    wr(8'h02, 8'h00);
    @(negedge clk);
    chk("R6 start after enable", load_start, 1);
    wr(8'h02, 8'h04);
    chk("R6 busy unaffected", load_busy, 1);
    pulse_done();
    rd(8'h03, v); chk("R6 load completes", v, 8'h01);
    soft_reset();
  endtask

  task automatic t_same_write();
    logic [7:0] v;
    strap_master = 1'b0;
    wr(8'h02, 8'h05);
    chk("R7 no start", load_start, 0);
    chk("R7 no busy", load_busy, 0);
    rd(8'h02, v); chk("R7 disable held", v, 8'h04);
    soft_reset();
  endtask

  task automatic t_error_timeout();
    logic [7:0] v;
    strap_master = 1'b0;
    wr(8'h02, 8'h01);
    chk("R10 busy", load_busy, 1);
    pulse_err();
    chk("R10 err back to armed", load_busy, 0);
    rd(8'h03, v); chk("R10 err flag", v, 8'h02);
    wr(8'h02, 8'h02);
    wr(8'h02, 8'h00);
    rd(8'h03, v); chk("R5 err cleared", v, 8'h00);
    wr(8'h02, 8'h01);
    chk("R10 restart", load_busy, 1);
    idle(TMO - 1);
    chk("R10 still busy", load_busy, 1);
    @(negedge clk);
    chk("R10 timeout", load_busy, 0);
    rd(8'h03, v); chk("R10 timeout flag", v, 8'h02);
  endtask

  initial begin
    fork
      begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_id();
        t_immediate_and_done();
        t_rearm();
        t_soft_and_pin();
        t_disable();
        t_same_write();
        t_error_timeout();
      end
      begin
        idle(20000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule